// File: doc/BRIEF.md
# Fuse-Programmable AND-OR Logic Array

This block models a small field-programmable sum-of-products device. Twelve dedicated inputs and ten feedback signals (one per output) form 22 array signals. Each signal enters a programmable AND plane in both true and inverted form. The plane holds 120 product terms. A fixed OR plane gives every output its own private, unequally sized group of those terms. Each OR result then passes through an output cell. Two configuration bits per output select one of four behaviours: registered or combinational, with the output either active-high or active-low. The cell also returns a feedback signal into the AND plane.

The whole configuration is shifted in one bit per configuration clock. First come 5280 AND-plane bits, then 20 cell-mode bits. A completion pulse then activates the device. Until that pulse arrives, every output pin reads 0 and every output register holds 0. A chip uses the block as a reprogrammable glue-logic island: load a bit image once after reset, then drive inputs and read outputs.

Top module: `pal_array`

## Requirements
- R1: Array signal s (0..21) is `in_i[s]` for s<12 and the feedback of output s-12 otherwise. Column 2s carries the signal true and column 2s+1 carries it inverted. A product term is the AND of the columns whose configuration bit is 1.
- R2: A product term with no configuration bit set is 0. A term that connects both columns of the same signal is also 0.
- R3: Outputs 0 to 9 own consecutive product-term groups of sizes 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8, starting at term 0. Each output's OR result is the OR of its own group only.
- R4: The mode of output o is {S1,S0}. 00 means registered with the pin showing the inverted register. 01 means registered with the pin showing the register. 10 means combinational with the inverted OR result. 11 means combinational with the OR result.
- R5: In combinational modes the pin follows the inputs with no clock delay. In registered modes the register loads the OR result on each rising `clk`, so the pin reflects the OR result of the previous cycle.
- R6: The feedback of a registered-mode output is its register (before polarity). The feedback of a combinational-mode output is `pin_in[o]`.
- R7: A synchronous `rst` clears every output register, the active state and the load position. The loaded configuration bits are kept.
- R8: With `cfg_en` high, each rising `cfg_clk` stores `cfg_data` at the next load position. Position k < 5280 is term k/44, column k%44. Position 5280+2o is S0 of output o and 5281+2o is S1. Bits beyond position 5299 are ignored.
- R9: `pin_out` is all 0 and output registers hold 0 until a `cfg_done` pulse (with `cfg_en` low) activates the device. That pulse also rewinds the load position. Any later `cfg_en` shift deactivates the device again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the output-cell registers |
| rst | input | 1 | Synchronous reset, active high |
| in_i | input | 12 | Dedicated array inputs |
| pin_in | input | 10 | Pin values fed back by outputs in combinational mode |
| pin_out | output | 10 | Output cell results |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Shift enable for one configuration bit |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_done | input | 1 | Pulse that activates the loaded configuration |

## Verification
The bench targets four kinds of error:

- **Empty or self-contradicting product terms.** A design that treats an empty term as 1 would force whole OR groups high.
- **Group boundaries between uneven OR sizes.** An off-by-one base would move a term to its neighbour's output.
- **Feedback source selection.** A design that fed back the polarised pin in registered mode, or the register in combinational mode, would diverge a cycle after any feedback-dependent term changes.
- **Load ordering and state handling.** The bench appends surplus bits and resets mid-run. Overflowing writes would corrupt the mode bits, and a reset that wiped the bit image would leave the outputs dead after re-activation.

// File: rtl/pal_pkg.sv
package pal_pkg;

   // Width of the OR group of output o among n_io outputs: symmetric ramp 8,10,..
   function automatic int grp_size(input int o, input int n_io);
      int k;
      k = (o < n_io / 2) ? o : (n_io - 1 - o);
      return 8 + 2 * k;
   endfunction

   // First product term owned by output o
   function automatic int grp_base(input int o, input int n_io);
      int acc;
      acc = 0;
      for (int i = 0; i < o; i++) acc += grp_size(i, n_io);
      return acc;
   endfunction

   function automatic int total_terms(input int n_io);
      return grp_base(n_io, n_io);
   endfunction

   typedef enum logic [1:0] {
      MODE_REG_LOW  = 2'b00,
      MODE_REG_HIGH = 2'b01,
      MODE_CMB_LOW  = 2'b10,
      MODE_CMB_HIGH = 2'b11
   } cell_mode_e;

endpackage

// File: rtl/pal_cfg_loader.sv
module pal_cfg_loader #(
   parameter int NTERM = 120,
   parameter int NCOL  = 44,
   parameter int N_IO  = 10
) (
   input  logic                            cfg_clk,
   input  logic                            rst,
   input  logic                            cfg_en,
   input  logic                            cfg_data,
   input  logic                            cfg_done,
   output logic [NTERM-1:0][NCOL-1:0]      fuse_o,
   output logic [2*N_IO-1:0]               mode_o,
   output logic                            ready_o
);
   localparam int MB = 2 * N_IO;
   localparam int TW = $clog2(NTERM + 1);
   localparam int CW = $clog2(NCOL);
   localparam int MW = $clog2(MB + 1);

   logic [NTERM-1:0][NCOL-1:0] fuse_q;
   logic [MB-1:0]              mode_q;
   logic [TW-1:0]              t_idx;
   logic [CW-1:0]              c_idx;
   logic [MW-1:0]              m_idx;
   logic                       ready_q;

   always_ff @(posedge cfg_clk) begin
      if (rst) begin
         t_idx   <= '0;
         c_idx   <= '0;
         m_idx   <= '0;
         ready_q <= 1'b0;
      end else if (cfg_en) begin
         ready_q <= 1'b0;
         if (t_idx < TW'(NTERM)) begin
            fuse_q[t_idx][c_idx] <= cfg_data;
            if (c_idx == CW'(NCOL - 1)) begin
               c_idx <= '0;
               t_idx <= t_idx + 1'b1;
            end else begin
               c_idx <= c_idx + 1'b1;
            end
         end else if (m_idx < MW'(MB)) begin
            mode_q[m_idx] <= cfg_data;
            m_idx         <= m_idx + 1'b1;
         end
      end else if (cfg_done) begin
         t_idx   <= '0;
         c_idx   <= '0;
         m_idx   <= '0;
         ready_q <= 1'b1;
      end
   end

   assign fuse_o  = fuse_q;
   assign mode_o  = mode_q;
   assign ready_o = ready_q;
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
   parameter int NSIG  = 22,
   parameter int NTERM = 120
) (
   input  logic [NSIG-1:0]                 sig_i,
   input  logic [NTERM-1:0][2*NSIG-1:0]    fuse_i,
   output logic [NTERM-1:0]                term_o
);
   localparam int NCOL = 2 * NSIG;

   logic [NCOL-1:0] lit;

   for (genvar s = 0; s < NSIG; s++) begin : g_lit
      assign lit[2*s]     = sig_i[s];
      assign lit[2*s + 1] = ~sig_i[s];
   end

   // A term needs at least one connection and every connected literal true
   for (genvar t = 0; t < NTERM; t++) begin : g_term
      assign term_o[t] = (|fuse_i[t]) & (&(lit | ~fuse_i[t]));
   end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
   parameter int N_IO  = 10,
   parameter int NTERM = 120
) (
   input  logic [NTERM-1:0] term_i,
   output logic [N_IO-1:0]  or_o
);
   for (genvar o = 0; o < N_IO; o++) begin : g_grp
      localparam int BASE = pal_pkg::grp_base(o, N_IO);
      localparam int SIZE = pal_pkg::grp_size(o, N_IO);
      assign or_o[o] = |term_i[BASE +: SIZE];
   end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell (
   input  logic       clk,
   input  logic       rst,
   input  logic       en_i,
   input  logic       or_i,
   input  logic [1:0] mode_i,
   input  logic       pin_fb_i,
   output logic       pin_o,
   output logic       fb_o
);
   import pal_pkg::*;

   logic       q;
   logic       reg_val;
   logic       cmb_val;
   cell_mode_e mode;

   assign mode = cell_mode_e'(mode_i);

   always_ff @(posedge clk) begin
      if (rst || !en_i) q <= 1'b0;
      else              q <= or_i;
   end

   assign reg_val = (mode == MODE_REG_HIGH) ? q : ~q;
   assign cmb_val = (mode == MODE_CMB_HIGH) ? or_i : ~or_i;

   always_comb begin
      if (!en_i)          pin_o = 1'b0;
      else if (mode_i[1]) pin_o = cmb_val;
      else                pin_o = reg_val;
   end

   assign fb_o = mode_i[1] ? pin_fb_i : q;
endmodule

// File: rtl/pal_array.sv
module pal_array #(
   parameter int N_IN = 12,
   parameter int N_IO = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_IN-1:0] in_i,
   input  logic [N_IO-1:0] pin_in,
   output logic [N_IO-1:0] pin_out,
   input  logic            cfg_clk,
   input  logic            cfg_en,
   input  logic            cfg_data,
   input  logic            cfg_done
);
   localparam int NSIG  = N_IN + N_IO;
   localparam int NCOL  = 2 * NSIG;
   localparam int NTERM = pal_pkg::total_terms(N_IO);

   if (N_IN < 1) begin : g_chk_in
      $error("pal_array: N_IN must be at least 1");
   end
   if ((N_IO < 2) || (N_IO % 2 != 0)) begin : g_chk_io
      $error("pal_array: N_IO must be even and at least 2");
   end

   logic [NTERM-1:0][NCOL-1:0] fuse;
   logic [2*N_IO-1:0]          mode_bits;
   logic                       cfg_ok;
   logic [NSIG-1:0]            sig;
   logic [NTERM-1:0]           term;
   logic [N_IO-1:0]            or_res;
   logic [N_IO-1:0]            fb;

   pal_cfg_loader #(.NTERM(NTERM), .NCOL(NCOL), .N_IO(N_IO)) u_load (
      .cfg_clk (cfg_clk),
      .rst     (rst),
      .cfg_en  (cfg_en),
      .cfg_data(cfg_data),
      .cfg_done(cfg_done),
      .fuse_o  (fuse),
      .mode_o  (mode_bits),
      .ready_o (cfg_ok)
   );

   assign sig = {fb, in_i};

   pal_and_plane #(.NSIG(NSIG), .NTERM(NTERM)) u_and (
      .sig_i (sig),
      .fuse_i(fuse),
      .term_o(term)
   );

   pal_or_plane #(.N_IO(N_IO), .NTERM(NTERM)) u_or (
      .term_i(term),
      .or_o  (or_res)
   );

   for (genvar o = 0; o < N_IO; o++) begin : g_cell
      pal_out_cell u_cell (
         .clk     (clk),
         .rst     (rst),
         .en_i    (cfg_ok),
         .or_i    (or_res[o]),
         .mode_i  (mode_bits[2*o +: 2]),
         .pin_fb_i(pin_in[o]),
         .pin_o   (pin_out[o]),
         .fb_o    (fb[o])
      );
   end
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
   parameter int N_IO = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_clk,
   input logic              cfg_en,
   input logic [N_IO-1:0]   pin_in,
   input logic [N_IO-1:0]   pin_out,
   input logic [N_IO-1:0]   or_res,
   input logic [N_IO-1:0]   fb,
   input logic [2*N_IO-1:0] mode_bits,
   input logic              cfg_ok
);
   // R9: a shift always leaves the pins dark
   a_r9_shift_dark: assert property (@(posedge cfg_clk) disable iff (rst)
      cfg_en |=> (pin_out == '0));

   // R9: inactive device drives zero
   a_r9_inactive_zero: assert property (@(posedge clk) disable iff (rst)
      !cfg_ok |-> (pin_out == '0));

   // R7: after a reset edge the pins are zero
   a_r7_reset_dark: assert property (@(posedge clk)
      rst |=> (pin_out == '0));

   for (genvar o = 0; o < N_IO; o++) begin : g_out
      // R5: registered pin reflects previous OR result
      a_r5_reg_next: assert property (@(posedge clk) disable iff (rst)
         (cfg_ok && $past(cfg_ok) && !$past(rst) && !mode_bits[2*o+1])
         |-> (pin_out[o] == (mode_bits[2*o] ? $past(or_res[o]) : !$past(or_res[o]))));

      // R6: registered feedback is the stored OR result
      a_r6_fb_reg: assert property (@(posedge clk) disable iff (rst)
         (cfg_ok && $past(cfg_ok) && !$past(rst) && !mode_bits[2*o+1])
         |-> (fb[o] == $past(or_res[o])));

      // R6: combinational feedback comes from the pin input
      a_r6_fb_cmb: assert property (@(posedge clk) disable iff (rst)
         (cfg_ok && mode_bits[2*o+1]) |-> (fb[o] == pin_in[o]));

      // R4: combinational polarity
      a_r4_cmb_pol: assert property (@(posedge clk) disable iff (rst)
         (cfg_ok && mode_bits[2*o+1])
         |-> (pin_out[o] == (mode_bits[2*o] ? or_res[o] : !or_res[o])));
   end
endmodule

bind pal_array pal_array_chk #(.N_IO(N_IO)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cfg_clk  (cfg_clk),
   .cfg_en   (cfg_en),
   .pin_in   (pin_in),
   .pin_out  (pin_out),
   .or_res   (or_res),
   .fb       (fb),
   .mode_bits(mode_bits),
   .cfg_ok   (cfg_ok)
);

// File: tb/pal_array_tb.sv
module pal_array_tb;
   localparam int NI    = 12;
   localparam int NO    = 10;
   localparam int NCOL  = 44;
   localparam int NTERM = 120;
   localparam int FUSES = NCOL * NTERM;
   localparam int CFG   = FUSES + 2 * NO;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NI-1:0] in_r = '0;
   logic [NO-1:0] pin_in_r = '0;
   logic [NO-1:0] pin_out;
   logic          cfg_en = 1'b0;
   logic          cfg_data = 1'b0;
   logic          cfg_done = 1'b0;

   always #5 clk = ~clk;

   pal_array u_dut (
      .clk(clk), .rst(rst), .in_i(in_r), .pin_in(pin_in_r), .pin_out(pin_out),
      .cfg_clk(clk), .cfg_en(cfg_en), .cfg_data(cfg_data), .cfg_done(cfg_done)
   );

   // ---------------- behavioural model ----------------
   bit          img [CFG];   // image being sent
   bit          mf  [CFG];   // what the model believes is loaded
   bit [NO-1:0] q_m;
   bit          conf_m;
   int          cnt_m;
   int          grp_sz [NO] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

   int    tests = 0;
   int    fails = 0;
   int    cyc   = 0;
   bit    checking = 0;
   string tag = "R7";
   int unsigned seed = 32'h1234_5678;

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   function automatic bit s1_of(int o); return mf[FUSES + 2*o + 1]; endfunction
   function automatic bit s0_of(int o); return mf[FUSES + 2*o];     endfunction

   function automatic bit sig_of(int s);
      if (s < NI) return in_r[s];
      return s1_of(s - NI) ? pin_in_r[s - NI] : q_m[s - NI];
   endfunction

   function automatic bit term_val(int t);
      bit any = 0;
      bit ok  = 1;
      for (int c = 0; c < NCOL; c++) begin
         if (mf[t*NCOL + c]) begin
            any = 1;
            if ((sig_of(c / 2) ^ bit'(c % 2)) == 1'b0) ok = 0;
         end
      end
      return any && ok;
   endfunction

   function automatic bit or_val(int o);
      int base = 0;
      bit r = 0;
      for (int i = 0; i < o; i++) base += grp_sz[i];
      for (int t = base; t < base + grp_sz[o]; t++) r |= term_val(t);
      return r;
   endfunction

   function automatic logic [NO-1:0] expect_pins();
      logic [NO-1:0] e = '0;
      if (!conf_m) return '0;
      for (int o = 0; o < NO; o++) begin
         if (s1_of(o)) e[o] = s0_of(o) ? or_val(o) : ~or_val(o);
         else          e[o] = s0_of(o) ? q_m[o] : ~q_m[o];
      end
      return e;
   endfunction

   always @(posedge clk) begin
      bit [NO-1:0] nq;
      nq = '0;
      if (rst) begin
         q_m = '0; conf_m = 0; cnt_m = 0;
      end else begin
         if (conf_m) for (int o = 0; o < NO; o++) nq[o] = or_val(o);
         if (cfg_en) begin
            if (cnt_m < CFG) begin mf[cnt_m] = cfg_data; cnt_m++; end
            conf_m = 0;
         end else if (cfg_done) begin
            conf_m = 1; cnt_m = 0;
         end
         q_m = nq;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      logic [NO-1:0] e;
      if (checking) begin
         e = expect_pins();
         tests++;
         if (pin_out !== e) begin
            fails++;
            $display("FAIL %s cycle %0d pin_out actual=%b expected=%b", tag, cyc, pin_out, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(bit en, bit d, bit done, bit rand_in);
      @(posedge clk); #1;
      cfg_en = en; cfg_data = d; cfg_done = done;
      if (rand_in) begin
         in_r     = NI'(rnd());
         pin_in_r = NO'(rnd());
      end
   endtask

   // R1 R2 R8: image with empty, conflicting and normal terms; modes rotated (R4)
   task automatic build_img(int rot);
      for (int k = 0; k < CFG; k++) img[k] = 0;
      for (int t = 0; t < NTERM; t++) begin
         int kind = int'(rnd() % 10);
         if (kind == 1) begin
            int s = int'(rnd() % 22);
            img[t*NCOL + 2*s]     = 1;
            img[t*NCOL + 2*s + 1] = 1;
         end else if (kind != 0) begin
            int n = (kind < 6) ? 2 : 1;
            for (int j = 0; j < n; j++) img[t*NCOL + int'(rnd() % NCOL)] = 1;
         end
      end
      for (int o = 0; o < NO; o++) begin
         int m = (o + rot) % 4;
         img[FUSES + 2*o]     = bit'(m % 2);
         img[FUSES + 2*o + 1] = bit'(m / 2);
      end
   endtask

   task automatic load(int extra);
      tag = "R9 R8 pins dark while loading";
      for (int k = 0; k < CFG; k++) step(1, img[k], 0, 1);
      tag = "R8 surplus bits ignored";
      for (int k = 0; k < extra; k++) step(1, 1, 0, 1);
      tag = "R9 activation";
      step(0, 0, 1, 1);
      step(0, 0, 0, 1);
   endtask

   task automatic run(int n, string t);
      tag = t;
      for (int k = 0; k < n; k++) step(0, 0, 0, 1);
   endtask

   initial begin
      q_m = '0; conf_m = 0; cnt_m = 0;
      for (int k = 0; k < CFG; k++) mf[k] = 0;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      checking = 1;
      tag = "R7 R9 reset state";
      step(0, 0, 0, 0);
      step(0, 0, 0, 1);
      for (int c = 0; c < 4; c++) begin
         build_img(c);
         load(c == 1 ? 3 : 0);
         run(300, "R1 R2 R3 R4 R5 R6 array and cells");
         if (c == 2) begin
            tag = "R7 mid-run reset";
            @(posedge clk); #1 rst = 1;
            @(posedge clk); #1 rst = 0;
            run(5, "R7 R9 dark after reset");
            tag = "R7 R8 image retained";
            step(0, 0, 1, 1);
            run(100, "R7 R8 image retained after reset");
         end
      end
      @(negedge clk);
      checking = 0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule